// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Conversion Sequencer

This block controls a four-channel sample-and-hold stage that feeds one successive-approximation converter. A rising start request freezes every channel at the same instant by raising a single hold line. The converter then digitizes the enabled channels one at a time, always in the order U, V, W, AUX. Each result is stored in a per-channel register that a host can read in any order. A start request is never lost: if it arrives before the input stage has reacquired, or while a group is still converting, it is queued until conversion is allowed.

When the group finishes, the block can flag completion in a status register that clears on read. It can also drive an active-low interrupt line, either as a one-clock pulse or as a level that holds until the status is read. A small register port carries control, status and results. The converter is outside the block: the sequencer names the channel being converted and takes the converter's 11-bit code at the end of each 40-clock slot.

Top module: `sh_adc_seq`

## Requirements
- R1: After reset the control and status registers read 0, all four result registers read 0, `irq_n` is 1, and `sh_hold` and `busy` are 0.
- R2: After reset, `sh_hold` stays low for at least 20 clocks. A start request made during that interval is deferred, not dropped: the hold begins no later than 21 clocks after reset release.
- R3: `sh_hold` stays high for exactly 40 clocks per enabled channel. With the reset control value, this is 80 clocks for two channels.
- R4: V and W are always converted. Control bit 3 adds U and control bit 4 adds AUX. `conv_ch` steps through the enabled channels in the order U=0, V=1, W=2, AUX=3.
- R5: Every channel's result is the code the converter holds for that channel from the moment `sh_hold` rises. Input changes after that moment have no effect on the results.
- R6: The result registers are at address 4 (U), 5 (V), 6 (W) and 7 (AUX). Each reads as the 11-bit code in bits 11:1 with bit 0 equal to 0. A channel that was not converted keeps its previous value.
- R7: A result register changes only when its own channel's slot ends. A read during a conversion returns the previous group's value.
- R8: Between the end of one group and the start of the next, `sh_hold` stays low for at least 20 clocks. A start request made while a group is converting raises `busy` and is carried out after that interval.
- R9: If control bit 7 is 1, the end of a group sets status bits 0 and 11, so the status register at address 1 reads 0x801. The read that returns these flags also clears them.
- R10: If control bit 7 is 0, the end of a group sets no status flag and `irq_n` stays 1.
- R11: If control bit 8 is 0, each flagged group drives `irq_n` low for exactly one clock.
- R12: If control bit 8 is 1, `irq_n` goes low at the end of the group and stays low until the status register is read. It is 1 from the clock after that read.
- R13: The control register at address 0 keeps only bits 3, 4, 7 and 8. Every other bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Start request; its rising level launches a group |
| bus_cs | input | 1 | Register port select |
| bus_wr | input | 1 | Register write strobe, one clock |
| bus_rd | input | 1 | Register read strobe, one clock |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, valid in the strobe cycle |
| sar_code | input | 11 | Converter code for the channel on `conv_ch` |
| sh_hold | output | 1 | 1 freezes all inputs (hold), 0 tracks |
| conv_ch | output | 2 | Channel being converted |
| busy | output | 1 | Group converting or start queued |
| irq_n | output | 1 | Active-low interrupt |

## Verification
If the slot counter or the channel walker is in a wrong state, the width of the `sh_hold` window or the `conv_ch` sequence is wrong. The first channel's slot exposes this within 40 clocks, and the complete group exposes it when `sh_hold` falls. A wrong acquisition count or pending flag either shortens the low gap before the next hold or loses the queued group entirely, which the bench sees within about 21 clocks. If the flags or result registers hold wrong values, this shows on the very next register read. An interrupt mode that lingers is seen one clock after the event.

// File: rtl/sh_adc_pkg.sv
package sh_adc_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = 2;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_RES0 = 4'd4;

  localparam int B_UEN   = 3;
  localparam int B_AUXEN = 4;
  localparam int B_IEN   = 7;
  localparam int B_LVL   = 8;
  localparam int S_ADC   = 0;
  localparam int S_ANY   = 11;

  function automatic logic [NCH-1:0] chan_mask(input logic u_en, input logic aux_en);
    return {aux_en, 1'b1, 1'b1, u_en};
  endfunction

  function automatic logic [CH_W-1:0] first_chan(input logic [NCH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = CH_W'(i);
    return r;
  endfunction

  function automatic logic has_next(input logic [NCH-1:0] m, input logic [CH_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (i > int'(c) && m[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [CH_W-1:0] next_chan(input logic [NCH-1:0] m, input logic [CH_W-1:0] c);
    logic [CH_W-1:0] r;
    r = c;
    for (int i = NCH - 1; i >= 0; i--)
      if (i > int'(c) && m[i]) r = CH_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/sh_start_gate.sv
module sh_start_gate #(
  parameter int ACQ_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic idle,
  input  logic grp_done,
  output logic go,
  output logic pend
);
  localparam int AW = $clog2(ACQ_CYC + 1);
  localparam logic [AW-1:0] ACQ_END = AW'(ACQ_CYC);

  logic [AW-1:0] acq_cnt;
  logic          start_q;
  logic          req;
  logic          acq_ok;

  assign req    = start_in & ~start_q;
  assign acq_ok = (acq_cnt == ACQ_END);
  assign go     = idle & acq_ok & (req | pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_cnt <= '0;
      start_q <= 1'b0;
      pend    <= 1'b0;
    end else begin
      start_q <= start_in;
      if (grp_done)                  acq_cnt <= '0;
      else if (idle && !acq_ok)      acq_cnt <= acq_cnt + 1'b1;
      if (go)                        pend <= 1'b0;
      else if (req)                  pend <= 1'b1;
    end
  end
endmodule

// File: rtl/sh_chan_walker.sv
module sh_chan_walker
  import sh_adc_pkg::*;
#(
  parameter int CONV_CYC = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [NCH-1:0]  mask_in,
  output logic            converting,
  output logic [CH_W-1:0] ch,
  output logic            slot_end,
  output logic            grp_done
);
  localparam int SW = $clog2(CONV_CYC);
  localparam logic [SW-1:0] SLOT_LAST = SW'(CONV_CYC - 1);

  logic [SW-1:0]  slot;
  logic [NCH-1:0] mask_q;
  logic           more;

  assign more     = has_next(mask_q, ch);
  assign slot_end = converting && (slot == SLOT_LAST);
  assign grp_done = slot_end && !more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      converting <= 1'b0;
      slot       <= '0;
      ch         <= '0;
      mask_q     <= '0;
    end else if (go) begin
      converting <= 1'b1;
      mask_q     <= mask_in;
      ch         <= first_chan(mask_in);
      slot       <= '0;
    end else if (converting) begin
      if (slot == SLOT_LAST) begin
        slot <= '0;
        if (more) ch <= next_chan(mask_q, ch);
        else      converting <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sh_irq_unit.sv
module sh_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic grp_done,
  input  logic ien,
  input  logic lvl_mode,
  input  logic stat_rd,
  output logic st_adc,
  output logic st_any,
  output logic irq_evt,
  output logic irq_n
);
  logic pulse_q;

  assign irq_evt = grp_done & ien;
  assign irq_n   = lvl_mode ? ~st_any : ~pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_adc  <= 1'b0;
      st_any  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= irq_evt;
      if (irq_evt) begin
        st_adc <= 1'b1;
        st_any <= 1'b1;
      end else if (stat_rd) begin
        st_adc <= 1'b0;
        st_any <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sh_adc_seq.sv
module sh_adc_seq
  import sh_adc_pkg::*;
#(
  parameter int ACQ_CYC  = 20,
  parameter int CONV_CYC = 40,
  parameter int CODE_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CODE_W:0]   bus_wdata,
  output logic [CODE_W:0]   bus_rdata,
  input  logic [CODE_W-1:0] sar_code,
  output logic              sh_hold,
  output logic [CH_W-1:0]   conv_ch,
  output logic              busy,
  output logic              irq_n
);
  localparam int DATA_W = CODE_W + 1;
  localparam logic [DATA_W-1:0] CTRL_KEEP =
    DATA_W'((1 << B_UEN) | (1 << B_AUXEN) | (1 << B_IEN) | (1 << B_LVL));

  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] res [NCH];
  logic [NCH*DATA_W-1:0] res_flat;
  logic [NCH-1:0]    res_we;
  logic              go, pend, converting, slot_end, grp_done;
  logic [CH_W-1:0]   ch;
  logic              stat_rd, ctrl_wr;
  logic              st_adc, st_any, irq_evt;

  assign stat_rd = bus_cs && bus_rd && (bus_addr == A_STAT);
  assign ctrl_wr = bus_cs && bus_wr && (bus_addr == A_CTRL);

  sh_start_gate #(.ACQ_CYC(ACQ_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .start_in(conv_start), .idle(!converting),
    .grp_done(grp_done), .go(go), .pend(pend)
  );

  sh_chan_walker #(.CONV_CYC(CONV_CYC)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go),
    .mask_in(chan_mask(ctrl[B_UEN], ctrl[B_AUXEN])),
    .converting(converting), .ch(ch), .slot_end(slot_end), .grp_done(grp_done)
  );

  sh_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .grp_done(grp_done), .ien(ctrl[B_IEN]),
    .lvl_mode(ctrl[B_LVL]), .stat_rd(stat_rd), .st_adc(st_adc),
    .st_any(st_any), .irq_evt(irq_evt), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= bus_wdata & CTRL_KEEP;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_res
      assign res_we[gi] = slot_end && (ch == CH_W'(gi));
      assign res_flat[gi*DATA_W +: DATA_W] = res[gi];
      always_ff @(posedge clk) begin
        if (!rst_n)          res[gi] <= '0;
        else if (res_we[gi]) res[gi] <= {sar_code, 1'b0};
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_cs && bus_rd) begin
      if (bus_addr == A_CTRL) bus_rdata = ctrl;
      else if (bus_addr == A_STAT) begin
        bus_rdata[S_ADC] = st_adc;
        bus_rdata[S_ANY] = st_any;
      end else if (bus_addr >= A_RES0 && bus_addr < A_RES0 + NCH)
        bus_rdata = res[CH_W'(bus_addr - A_RES0)];
    end
  end

  assign sh_hold = converting;
  assign conv_ch = ch;
  assign busy    = converting | pend;
endmodule

// File: rtl/sh_adc_seq_chk.sv
module sh_adc_seq_chk #(
  parameter int ACQ_CYC = 20,
  parameter int RES_W   = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sh_hold,
  input logic             irq_n,
  input logic             irq_lvl,
  input logic             stat_rd,
  input logic             irq_evt,
  input logic             st_any,
  input logic             grp_done,
  input logic [3:0]       res_we,
  input logic [RES_W-1:0] res_flat
);
  localparam int LW = $clog2(ACQ_CYC + 1);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         low_cnt <= '0;
    else if (sh_hold)                   low_cnt <= '0;
    else if (low_cnt != LW'(ACQ_CYC))   low_cnt <= low_cnt + 1'b1;
  end

  // R8
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_hold) |-> (low_cnt >= LW'(ACQ_CYC)));

  // R3
  grp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_hold) |-> $past(grp_done));

  // R9
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_evt) |=> !st_any);

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_lvl && !irq_n) |=> (irq_n || irq_lvl));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we == 4'b0) |=> $stable(res_flat));
endmodule

bind sh_adc_seq sh_adc_seq_chk #(.ACQ_CYC(ACQ_CYC), .RES_W(4 * (CODE_W + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_hold(sh_hold), .irq_n(irq_n),
  .irq_lvl(ctrl[8]), .stat_rd(stat_rd), .irq_evt(irq_evt), .st_any(st_any),
  .grp_done(grp_done), .res_we(res_we), .res_flat(res_flat)
);

// File: tb/sim_sh_adc_seq.sv
module sim_sh_adc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic        bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic [10:0] sar_code;
  logic        sh_hold, busy, irq_n;
  logic [1:0]  conv_ch;

  logic [10:0] live [4];
  logic [10:0] held [4];
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sh_adc_seq u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .bus_cs(bus_cs),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sar_code(sar_code), .sh_hold(sh_hold),
    .conv_ch(conv_ch), .busy(busy), .irq_n(irq_n)
  );

  // converter stub: freezes every input when the hold line rises
  always @(posedge sh_hold) for (int i = 0; i < 4; i++) held[i] <= live[i];
  assign sar_code = held[conv_ch];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk); bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [11:0] d);
    @(negedge clk); bus_cs = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_cs = 0; bus_rd = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
  endtask

  task automatic wait_rise(output int lows);
    lows = 0;
    for (int i = 0; i < 1000 && !sh_hold; i++) begin
      @(negedge clk);
      if (!sh_hold) lows++;
    end
  endtask

  task automatic count_hold(output int highs, output int seq, output int irqlows);
    int last;
    highs = 0; seq = 0; irqlows = 0; last = -1;
    for (int i = 0; i < 1000 && sh_hold; i++) begin
      highs++;
      if (int'(conv_ch) != last) begin seq = seq * 10 + int'(conv_ch) + 1; last = int'(conv_ch); end
      if (!irq_n) irqlows++;
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      if (!irq_n) irqlows++;
      @(negedge clk);
    end
  endtask

  task automatic run_group(output int highs, output int seq, output int irqlows);
    int lows;
    pulse_start();
    wait_rise(lows);
    count_hold(highs, seq, irqlows);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    logic [11:0] d;
    do_reset();
    chk(irq_n == 1 && sh_hold == 0 && busy == 0, "R1 pins", {irq_n, sh_hold, busy}, 3'b100);
    rd(4'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(4'd1, d); chk(d == 0, "R1 status", d, 0);
    for (int a = 4; a < 8; a++) begin rd(4'(a), d); chk(d == 0, "R1 result", d, 0); end
    wr(4'd0, 12'hFFF);
    rd(4'd0, d); chk(d == 12'h198, "R13 ctrl mask", d, 12'h198);
    wr(4'd0, 12'h000);
  endtask

  task automatic t_early();
    int lows, highs, seq, irql;
    logic [11:0] d;
    live[0] = 11'h123; live[1] = 11'h456; live[2] = 11'h7FF; live[3] = 11'h001;
    do_reset();
    @(negedge clk); conv_start = 1;
    lows = sh_hold ? 0 : 1;
    @(negedge clk); conv_start = 0;
    if (!sh_hold) lows++;
    begin int more; wait_rise(more); lows += more; end
    chk(lows >= 20 && lows <= 21, "R2 deferred start", lows, 20);
    count_hold(highs, seq, irql);
    chk(highs == 80, "R3 two-channel hold", highs, 80);
    chk(seq == 23, "R4 default order", seq, 23);
    rd(4'd5, d); chk(d == 12'h8AC, "R6 V result", d, 12'h8AC);
    rd(4'd6, d); chk(d == 12'hFFE, "R6 W result", d, 12'hFFE);
    rd(4'd4, d); chk(d == 0, "R6 U untouched", d, 0);
    rd(4'd7, d); chk(d == 0, "R6 AUX untouched", d, 0);
  endtask

  task automatic t_sets();
    int highs, seq, irql;
    logic [11:0] d;
    wr(4'd0, 12'h008);
    run_group(highs, seq, irql);
    chk(highs == 120, "R3 U+V+W hold", highs, 120);
    chk(seq == 123, "R4 order with U", seq, 123);
    rd(4'd4, d); chk(d == 12'h246, "R6 U result", d, 12'h246);
    rd(4'd7, d); chk(d == 0, "R6 AUX untouched", d, 0);
    wr(4'd0, 12'h010);
    run_group(highs, seq, irql);
    chk(highs == 120, "R3 V+W+AUX hold", highs, 120);
    chk(seq == 234, "R4 order with AUX", seq, 234);
    rd(4'd7, d); chk(d == 12'h002, "R6 AUX result", d, 12'h002);
    live[0] = 11'h400; live[3] = 11'h3FF;
    wr(4'd0, 12'h018);
    run_group(highs, seq, irql);
    chk(highs == 160, "R3 four-channel hold", highs, 160);
    chk(seq == 1234, "R4 full order", seq, 1234);
    rd(4'd4, d); chk(d == 12'h800, "R6 U negative", d, 12'h800);
    rd(4'd7, d); chk(d == 12'h7FE, "R6 AUX positive max", d, 12'h7FE);
  endtask

  task automatic t_simul();
    int lows, highs, seq, irql;
    logic [11:0] d;
    live[0] = 11'h011; live[1] = 11'h022; live[2] = 11'h033; live[3] = 11'h044;
    pulse_start();
    wait_rise(lows);
    repeat (2) @(negedge clk);
    live[0] = 11'h555; live[1] = 11'h555; live[2] = 11'h555; live[3] = 11'h555;
    rd(4'd5, d); chk(d == 12'h8AC, "R7 read during conversion", d, 12'h8AC);
    count_hold(highs, seq, irql);
    rd(4'd4, d); chk(d == 12'h022, "R5 U frozen", d, 12'h022);
    rd(4'd5, d); chk(d == 12'h044, "R5 V frozen", d, 12'h044);
    rd(4'd6, d); chk(d == 12'h066, "R5 W frozen", d, 12'h066);
    rd(4'd7, d); chk(d == 12'h088, "R5 AUX frozen", d, 12'h088);
  endtask

  task automatic t_defer();
    int lows, highs, seq, irql;
    wr(4'd0, 12'h000);
    pulse_start();
    wait_rise(lows);
    repeat (30) @(negedge clk);
    pulse_start();
    chk(busy == 1, "R8 busy while queued", busy, 1);
    for (int i = 0; i < 1000 && sh_hold; i++) @(negedge clk);
    chk(busy == 1, "R8 queued start kept", busy, 1);
    wait_rise(lows);
    chk(sh_hold && lows >= 20, "R8 reacquire gap", lows, 20);
    count_hold(highs, seq, irql);
    chk(highs == 80, "R8 queued group ran", highs, 80);
  endtask

  task automatic t_irq_edge();
    int highs, seq, irql;
    logic [11:0] d;
    wr(4'd0, 12'h080);
    run_group(highs, seq, irql);
    chk(irql == 1, "R11 one-clock pulse", irql, 1);
    rd(4'd1, d); chk(d == 12'h801, "R9 status flags", d, 12'h801);
    rd(4'd1, d); chk(d == 0, "R9 cleared on read", d, 0);
  endtask

  task automatic t_irq_off();
    int highs, seq, irql;
    logic [11:0] d;
    wr(4'd0, 12'h100);
    run_group(highs, seq, irql);
    chk(irql == 0, "R10 no interrupt", irql, 0);
    rd(4'd1, d); chk(d == 0, "R10 no status", d, 0);
  endtask

  task automatic t_irq_level();
    int highs, seq, irql;
    logic [11:0] d;
    wr(4'd0, 12'h180);
    run_group(highs, seq, irql);
    repeat (5) @(negedge clk);
    chk(irq_n == 0, "R12 level held", irq_n, 0);
    rd(4'd1, d); chk(d == 12'h801, "R12 status", d, 12'h801);
    chk(irq_n == 1, "R12 released by read", irq_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) live[i] = '0;
    t_reset();
    t_early();
    t_sets();
    t_simul();
    t_defer();
    t_irq_edge();
    t_irq_off();
    t_irq_level();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule